// File: doc/BRIEF.md
# Bridge Fault Supervisor

This block watches the health of a pair of motor power bridges and decides, every clock, whether each bridge may conduct. It takes a digitized supply reading in millivolts, a die temperature in whole degrees and one overcurrent flag per bridge. It drives one enable gate per bridge, together with live and sticky fault indications.

Supply and temperature faults use separate trip and release levels, so a reading near a threshold cannot make the lockout chatter. Either of these faults blocks every bridge. An overcurrent acts only on the bridge that reported it. That bridge is switched off after a short, fixed detection delay and is held off for a programmable number of cycles. It then comes back on by itself. A new overcurrent report during the off period starts the off period again.

Each fault class also has a sticky bit. The bit is set when the fault begins and stays set until a clear pulse arrives. If a fault begins in the same cycle as the clear pulse, the bit stays set.

Top module: `bridge_fault_sup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, uv_lock is 1, ot_lock is 0, every oc_off bit is 0, every sticky bit is 0 and bridge_en is all zeros.
- R2: uv_lock clears one clock edge after the block samples supply_mv greater than UV_REL_MV (7000). It sets one edge after the block samples supply_mv less than UV_TRIP_MV (6000). For readings from 6000 to 7000 inclusive, uv_lock keeps its value.
- R3: ot_lock sets one edge after the block samples temp_c of OT_TRIP_C (165) or more. It clears one edge after the block samples temp_c less than OT_REL_C (150). For readings from 150 to 164, ot_lock keeps its value.
- R4: bridge_en[b] is 1 only when uv_lock is 0, ot_lock is 0 and oc_off[b] is 0. A supply or temperature lockout therefore disables every bridge.
- R5: Edge k is the first edge at which bridge b is running and samples oc_flag[b] high. bridge_en[b] stays 1 through edge k+OC_DLY-1 and falls at edge k+OC_DLY, even if the flag has already gone low. The other bridges are not affected.
- R6: Once a bridge has been switched off for overcurrent, it stays off for exactly DIS_CYC edges and then re-enables without any other input.
- R7: If the block samples oc_flag[b] high at an edge while bridge b is off, the off period restarts, and the bridge re-enables DIS_CYC edges after that edge.
- R8: The block sets sticky_uv at the edge where uv_lock rises, sticky_ot where ot_lock rises, and sticky_oc[b] at edge k of R5. A sticky bit holds its value until the block samples sts_clr high. Setting takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_mv | input | VW | Supply voltage sample, millivolts |
| temp_c | input | TW | Die temperature sample, degrees |
| oc_flag | input | NB | Per-bridge overcurrent detect |
| sts_clr | input | 1 | Clear pulse for the sticky bits |
| bridge_en | output | NB | Per-bridge enable gate |
| uv_lock | output | 1 | Supply lockout active |
| ot_lock | output | 1 | Thermal lockout active |
| oc_off | output | NB | Bridge held off after an overcurrent |
| sticky_uv | output | 1 | Supply fault recorded |
| sticky_ot | output | 1 | Thermal fault recorded |
| sticky_oc | output | NB | Overcurrent recorded, per bridge |

## Verification
The bench builds the block with OC_DLY set to 3 and DIS_CYC set to 40, in place of the slow defaults. At these values complete off windows, restarts inside a window and automatic recoveries all happen many times within a few thousand cycles. The supply and temperature thresholds keep their default values of 6000 mV, 7000 mV, 165 and 150 degrees. The random readings are drawn from bands that straddle these levels, so the trip, release and hold regions are all exercised, along with the exact boundary values.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    OC_IDLE = 2'd0,
    OC_PEND = 2'd1,
    OC_OFF  = 2'd2
  } oc_state_t;
endpackage

// File: rtl/bfs_hyst.sv
// Two-threshold lockout flag. TRIP_HIGH selects the polarity:
// 1 = fault when the sample is high (temperature), 0 = fault when low (supply).
module bfs_hyst #(
  parameter int unsigned W          = 16,
  parameter int unsigned TRIP       = 6000,
  parameter int unsigned REL        = 7000,
  parameter bit          TRIP_HIGH  = 1'b0,
  parameter bit          RST_ACTIVE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  output logic         active,
  output logic         trip_evt
);
  localparam logic [W-1:0] TRIP_W = W'(TRIP);
  localparam logic [W-1:0] REL_W  = W'(REL);

  logic trip_cond;
  logic rel_cond;
  logic act_q;
  logic act_d;

  generate
    if (TRIP_HIGH) begin : g_high
      assign trip_cond = (sample >= TRIP_W);
      assign rel_cond  = (sample <  REL_W);
    end else begin : g_low
      assign trip_cond = (sample <  TRIP_W);
      assign rel_cond  = (sample >  REL_W);
    end
  endgenerate

  always_comb begin
    act_d = act_q;
    if (!act_q && trip_cond) begin
      act_d = 1'b1;
    end else if (act_q && rel_cond) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RST_ACTIVE;
    end else begin
      act_q <= act_d;
    end
  end

  assign active   = act_q;
  assign trip_evt = !act_q && act_d;
endmodule

// File: rtl/bfs_oc_timer.sv
// Per-bridge overcurrent sequencer: detection delay, then a timed off window
// that restarts on every further report.
module bfs_oc_timer
  import bfs_pkg::*;
#(
  parameter int unsigned DLY = 20,
  parameter int unsigned DIS = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  output logic off,
  output logic start_evt
);
  localparam int unsigned CMAX = (DLY > DIS) ? DLY : DIS;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DLY - 1);
  localparam logic [CW-1:0] DIS_LAST = CW'(DIS - 1);

  oc_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      OC_IDLE: begin
        if (oc_flag) begin
          state_d = OC_PEND;
          cnt_d   = '0;
        end
      end
      OC_PEND: begin
        if (cnt_q == DLY_LAST) begin
          state_d = OC_OFF;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      OC_OFF: begin
        if (oc_flag) begin
          cnt_d = '0;
        end else if (cnt_q == DIS_LAST) begin
          state_d = OC_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = OC_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OC_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign off       = (state_q == OC_OFF);
  assign start_evt = (state_q == OC_IDLE) && oc_flag;
endmodule

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup #(
  parameter int unsigned NB         = 2,
  parameter int unsigned VW         = 16,
  parameter int unsigned TW         = 8,
  parameter int unsigned UV_TRIP_MV = 6000,
  parameter int unsigned UV_REL_MV  = 7000,
  parameter int unsigned OT_TRIP_C  = 165,
  parameter int unsigned OT_REL_C   = 150,
  parameter int unsigned OC_DLY     = 20,
  parameter int unsigned DIS_CYC    = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] supply_mv,
  input  logic [TW-1:0] temp_c,
  input  logic [NB-1:0] oc_flag,
  input  logic          sts_clr,
  output logic [NB-1:0] bridge_en,
  output logic          uv_lock,
  output logic          ot_lock,
  output logic [NB-1:0] oc_off,
  output logic          sticky_uv,
  output logic          sticky_ot,
  output logic [NB-1:0] sticky_oc
);
  logic          uv_evt;
  logic          ot_evt;
  logic [NB-1:0] oc_evt;
  logic          global_ok;

  bfs_hyst #(
    .W(VW), .TRIP(UV_TRIP_MV), .REL(UV_REL_MV),
    .TRIP_HIGH(1'b0), .RST_ACTIVE(1'b1)
  ) u_uv (
    .clk(clk), .rst_n(rst_n), .sample(supply_mv),
    .active(uv_lock), .trip_evt(uv_evt)
  );

  bfs_hyst #(
    .W(TW), .TRIP(OT_TRIP_C), .REL(OT_REL_C),
    .TRIP_HIGH(1'b1), .RST_ACTIVE(1'b0)
  ) u_ot (
    .clk(clk), .rst_n(rst_n), .sample(temp_c),
    .active(ot_lock), .trip_evt(ot_evt)
  );

  assign global_ok = !uv_lock && !ot_lock;

  // Sticky records: enable on set or clear, data equals set (set wins).
  logic st_uv_en, st_uv_d, st_ot_en, st_ot_d;

  always_comb begin
    st_uv_en = uv_evt | sts_clr;
    st_uv_d  = uv_evt;
    st_ot_en = ot_evt | sts_clr;
    st_ot_d  = ot_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_uv <= 1'b0;
    end else if (st_uv_en) begin
      sticky_uv <= st_uv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_ot <= 1'b0;
    end else if (st_ot_en) begin
      sticky_ot <= st_ot_d;
    end
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_br
      logic st_oc_en;
      logic st_oc_d;

      bfs_oc_timer #(.DLY(OC_DLY), .DIS(DIS_CYC)) u_oc (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag[b]),
        .off(oc_off[b]), .start_evt(oc_evt[b])
      );

      always_comb begin
        st_oc_en = oc_evt[b] | sts_clr;
        st_oc_d  = oc_evt[b];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sticky_oc[b] <= 1'b0;
        end else if (st_oc_en) begin
          sticky_oc[b] <= st_oc_d;
        end
      end

      assign bridge_en[b] = global_ok && !oc_off[b];
    end
  endgenerate
endmodule

// File: rtl/bfs_chk.sv
module bfs_chk #(
  parameter int unsigned NB         = 2,
  parameter int unsigned VW         = 16,
  parameter int unsigned TW         = 8,
  parameter int unsigned UV_TRIP_MV = 6000,
  parameter int unsigned UV_REL_MV  = 7000,
  parameter int unsigned OT_TRIP_C  = 165,
  parameter int unsigned OT_REL_C   = 150
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] supply_mv,
  input logic [TW-1:0] temp_c,
  input logic [NB-1:0] oc_flag,
  input logic          sts_clr,
  input logic [NB-1:0] bridge_en,
  input logic          uv_lock,
  input logic          ot_lock,
  input logic [NB-1:0] oc_off,
  input logic          sticky_uv,
  input logic          sticky_ot
);
  localparam logic [VW-1:0] UVT = VW'(UV_TRIP_MV);
  localparam logic [VW-1:0] UVR = VW'(UV_REL_MV);
  localparam logic [TW-1:0] OTT = TW'(OT_TRIP_C);
  localparam logic [TW-1:0] OTR = TW'(OT_REL_C);

  AST_UV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_lock && supply_mv > UVR) |=> !uv_lock); // R2
  AST_UV_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_lock && supply_mv < UVT) |=> uv_lock); // R2
  AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_mv >= UVT && supply_mv <= UVR) |=> $stable(uv_lock)); // R2
  AST_OT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ot_lock && temp_c >= OTT) |=> ot_lock); // R3
  AST_OT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_lock && temp_c < OTR) |=> !ot_lock); // R3
  AST_GATE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_lock || ot_lock) |-> (bridge_en == '0)); // R4
  AST_STICKY_UV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_lock) |-> sticky_uv); // R8
  AST_STICKY_OT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ot_lock) |-> sticky_ot); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_uv && !sts_clr) |=> sticky_uv); // R8

  generate
    for (genvar b = 0; b < NB; b++) begin : g_a
      AST_OC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_off[b] && oc_flag[b]) |=> oc_off[b]); // R7
      AST_OC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        oc_off[b] |-> !bridge_en[b]); // R4
    end
  endgenerate
endmodule

bind bridge_fault_sup bfs_chk #(
  .NB(NB), .VW(VW), .TW(TW),
  .UV_TRIP_MV(UV_TRIP_MV), .UV_REL_MV(UV_REL_MV),
  .OT_TRIP_C(OT_TRIP_C), .OT_REL_C(OT_REL_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_mv(supply_mv), .temp_c(temp_c),
  .oc_flag(oc_flag), .sts_clr(sts_clr), .bridge_en(bridge_en),
  .uv_lock(uv_lock), .ot_lock(ot_lock), .oc_off(oc_off),
  .sticky_uv(sticky_uv), .sticky_ot(sticky_ot)
);

// File: tb/sim_bridge_fault_sup.sv
`timescale 1ns/1ps
module sim_bridge_fault_sup;
  localparam int NB  = 2;
  localparam int VW  = 16;
  localparam int TW  = 8;
  localparam int DLY = 3;
  localparam int DIS = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] supply_mv = '0;
  logic [TW-1:0] temp_c = '0;
  logic [NB-1:0] oc_flag = '0;
  logic          sts_clr = 1'b0;
  logic [NB-1:0] bridge_en, oc_off, sticky_oc;
  logic          uv_lock, ot_lock, sticky_uv, sticky_ot;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bridge_fault_sup #(.NB(NB), .VW(VW), .TW(TW), .OC_DLY(DLY), .DIS_CYC(DIS)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_mv(supply_mv), .temp_c(temp_c),
    .oc_flag(oc_flag), .sts_clr(sts_clr), .bridge_en(bridge_en),
    .uv_lock(uv_lock), .ot_lock(ot_lock), .oc_off(oc_off),
    .sticky_uv(sticky_uv), .sticky_ot(sticky_ot), .sticky_oc(sticky_oc)
  );

  // Reference model, written from the requirements.
  logic m_uv, m_ot, m_suv, m_sot;
  int   m_st [NB];
  int   m_cnt [NB];
  logic [NB-1:0] m_soc;

  function automatic logic next_uv(logic cur, int v);
    if (!cur && v < 6000) return 1'b1;
    if (cur && v > 7000) return 1'b0;
    return cur;
  endfunction

  function automatic logic next_ot(logic cur, int t);
    if (!cur && t >= 165) return 1'b1;
    if (cur && t < 150) return 1'b0;
    return cur;
  endfunction

  function automatic logic [NB-1:0] exp_en();
    logic [NB-1:0] e;
    for (int b = 0; b < NB; b++) e[b] = !m_uv && !m_ot && (m_st[b] != 2);
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_uv <= 1'b1; m_ot <= 1'b0; m_suv <= 1'b0; m_sot <= 1'b0; m_soc <= '0;
      for (int b = 0; b < NB; b++) begin m_st[b] <= 0; m_cnt[b] <= 0; end
    end else begin
      logic nu, no;
      nu = next_uv(m_uv, int'(supply_mv));
      no = next_ot(m_ot, int'(temp_c));
      m_suv <= (!m_uv && nu) ? 1'b1 : (sts_clr ? 1'b0 : m_suv);
      m_sot <= (!m_ot && no) ? 1'b1 : (sts_clr ? 1'b0 : m_sot);
      m_uv <= nu;
      m_ot <= no;
      for (int b = 0; b < NB; b++) begin
        logic set;
        set = (m_st[b] == 0) && oc_flag[b];
        m_soc[b] <= set ? 1'b1 : (sts_clr ? 1'b0 : m_soc[b]);
        case (m_st[b])
          0: if (oc_flag[b]) begin m_st[b] <= 1; m_cnt[b] <= 0; end
          1: if (m_cnt[b] == DLY - 1) begin m_st[b] <= 2; m_cnt[b] <= 0; end
             else m_cnt[b] <= m_cnt[b] + 1;
          default: if (oc_flag[b]) m_cnt[b] <= 0;
             else if (m_cnt[b] == DIS - 1) begin m_st[b] <= 0; m_cnt[b] <= 0; end
             else m_cnt[b] <= m_cnt[b] + 1;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, expv);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      logic [NB-1:0] moff;
      for (int b = 0; b < NB; b++) moff[b] = (m_st[b] == 2);
      chk("R2 uv_lock", 32'(uv_lock), 32'(m_uv));
      chk("R3 ot_lock", 32'(ot_lock), 32'(m_ot));
      chk("R4 bridge_en", 32'(bridge_en), 32'(exp_en()));
      chk("R6 oc_off", 32'(oc_off), 32'(moff));
      chk("R8 sticky", {29'd0, sticky_uv, sticky_ot, 1'b0} | 32'(sticky_oc) << 3,
          {29'd0, m_suv, m_sot, 1'b0} | 32'(m_soc) << 3);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    supply_mv = 16'd0; temp_c = 8'd25;
    cyc(2);
    // R1 during reset
    chk("R1 uv_lock in reset", 32'(uv_lock), 32'd1);
    chk("R1 bridge_en in reset", 32'(bridge_en), 32'd0);
    chk("R1 sticky in reset", 32'({sticky_uv, sticky_ot, sticky_oc}), 32'd0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 ot_lock after reset", 32'(ot_lock), 32'd0);
    chk("R1 oc_off after reset", 32'(oc_off), 32'd0);

    // R2 boundaries
    supply_mv = 16'd7000; cyc(1);
    chk("R2 hold at 7000", 32'(uv_lock), 32'd1);
    supply_mv = 16'd7001; cyc(1);
    chk("R2 release above 7000", 32'(uv_lock), 32'd0);
    chk("R4 both enabled", 32'(bridge_en), 32'd3);
    supply_mv = 16'd6000; cyc(1);
    chk("R2 hold at 6000", 32'(uv_lock), 32'd0);
    supply_mv = 16'd5999; cyc(1);
    chk("R2 trip below 6000", 32'(uv_lock), 32'd1);
    chk("R8 sticky_uv set", 32'(sticky_uv), 32'd1);
    chk("R4 lockout disables all", 32'(bridge_en), 32'd0);
    supply_mv = 16'd8000; cyc(1);

    // R3 boundaries
    temp_c = 8'd164; cyc(1);
    chk("R3 hold at 164", 32'(ot_lock), 32'd0);
    temp_c = 8'd165; cyc(1);
    chk("R3 trip at 165", 32'(ot_lock), 32'd1);
    chk("R4 thermal disables all", 32'(bridge_en), 32'd0);
    temp_c = 8'd150; cyc(1);
    chk("R3 hold at 150", 32'(ot_lock), 32'd1);
    temp_c = 8'd149; cyc(1);
    chk("R3 release below 150", 32'(ot_lock), 32'd0);
    sts_clr = 1'b1; cyc(1); sts_clr = 1'b0;
    chk("R8 clear", 32'({sticky_uv, sticky_ot}), 32'd0);

    // R5 / R6: one-cycle pulse on bridge 0
    oc_flag = 2'b01; cyc(1); oc_flag = 2'b00;
    chk("R8 sticky_oc set", 32'(sticky_oc), 32'd1);
    cyc(DLY - 1);
    chk("R5 still on before delay", 32'(bridge_en), 32'd3);
    cyc(1);
    chk("R5 off after delay, other unaffected", 32'(bridge_en), 32'd2);
    cyc(DIS - 1);
    chk("R6 still off at end-1", 32'(bridge_en[0]), 32'd0);
    cyc(1);
    chk("R6 auto re-enable", 32'(bridge_en[0]), 32'd1);

    // R7: restart during off window on bridge 1
    oc_flag = 2'b10; cyc(1); oc_flag = 2'b00;
    cyc(DLY + 20);
    oc_flag = 2'b10; cyc(1); oc_flag = 2'b00;
    cyc(DIS - 1);
    chk("R7 restarted window still off", 32'(bridge_en[1]), 32'd0);
    cyc(1);
    chk("R7 re-enable after restart", 32'(bridge_en[1]), 32'd1);

    // Random phase A: readings straddle thresholds
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 4 == 0) supply_mv = 16'(5800 + $urandom % 1400);
      if ($urandom % 4 == 0) temp_c = 8'(140 + $urandom % 35);
      oc_flag = NB'($urandom % 30 == 0 ? $urandom : 0);
      sts_clr = ($urandom % 20 == 0);
      cyc(1);
    end
    // Random phase B: healthy supply, frequent overcurrent
    supply_mv = 16'd9000; temp_c = 8'd60;
    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < NB; b++) oc_flag[b] = ($urandom % 25 == 0);
      sts_clr = ($urandom % 15 == 0);
      cyc(1);
    end
    oc_flag = '0; sts_clr = 1'b0;
    cyc(2);
    finish_run();
  end
endmodule